// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a warp's load/store issue stage and the memory pipeline. It takes one request covering 32 lanes at a time. Each lane brings its own byte address, and the request also carries a lane-active mask, an element-size code and a mode. The block breaks the request into aligned memory transactions and emits them one per cycle on a valid/ready output. Each transaction names an aligned segment address and the set of lanes whose data lies inside that segment.

The number of transactions is not fixed. It depends on how the active addresses group, and it is worked out while the block is busy. The request is replayed once per transaction until no active lane is left unserved. On each pass the lowest-numbered unserved lane acts as leader. Its segment becomes the transaction address, and every unserved lane that falls in the same segment is retired in that pass.

Two relaxed modes merge any lanes that share a segment, whatever their order. One uses 128-byte segments and the other uses 32-byte segments. A strict mode treats each 16-lane half separately. A half merges only when its lanes lie in exact sequential word order; otherwise it falls back to one transaction per active lane. A single-cycle pulse marks the end of each request.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `txValid` and `done` are low and `reqReady` is high.
- R2: Mode code 0 (cached) emits transactions whose address is the leader lane's address rounded down to a 128-byte boundary. The leader is the lowest-numbered unserved active lane. The lane set is every unserved active lane in that 128-byte block, and served lanes never reappear.
- R3: Mode code 1 (uncached) behaves as R2 with 32-byte segments.
- R4: Inactive lanes never appear in `txLanes`. A request with an all-zero mask issues no transaction and raises `done` in the cycle after it is accepted.
- R5: In a relaxed mode, a request whose active lanes all hold the same address completes in exactly one transaction.
- R6: Mode code 2 (strict) uses size code s (0..4 for 1, 2, 4, 8 and 16-byte elements). A 16-lane half merges when, for every active lane at position k in the half, the address equals B + k·2^s, where B is aligned to 16·2^s bytes. Inactive lanes are exempt. For s < 4 a merged half is one transaction with address B, covering the half's active lanes.
- R7: In strict mode with s = 4, a merged half is issued as two transactions. Lanes 0–7 of the half use address B and lanes 8–15 use B+128, each covering the active lanes of its eight.
- R8: In strict mode a half that fails the R6 pattern issues one transaction per active lane, in ascending lane order. Each transaction's address is that lane's address rounded down to 32 bytes.
- R9: While `txValid` is high and `txReady` is low, `txValid`, `txAddr` and `txLanes` hold their values.
- R10: `done` pulses for one cycle, in the cycle after the last transaction handshake. `reqReady` is low while transactions are pending, and a request offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request accepted on this edge |
| reqAddr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| reqMask | input | LANES | Lane-active mask |
| reqSize | input | 3 | Element size code 0..4 = 1/2/4/8/16 bytes |
| reqMode | input | 2 | 0 cached, 1 uncached, 2 strict |
| txValid | output | 1 | Transaction present |
| txReady | input | 1 | Downstream takes the transaction |
| txAddr | output | ADDR_W | Aligned segment address |
| txLanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties watch every cycle for several things: output stability under backpressure, removal of served lanes after each handshake, segment alignment in the relaxed modes, the single-lane shape of strict fallback transactions, exclusion of inactive lanes, and the timing of the `done` pulse. Whether the grouping is minimal and correct for a given address pattern can only be shown by the bench. It compares the exact sequence of addresses and lane sets, and the transaction count, against an independent model. The patterns it uses include sequential strides, broadcasts, scattered windows, broken strict orderings and 16-byte elements.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
  localparam int GROUP_LANES  = 16;   // strict-mode lane group
  localparam int CACHED_SEG   = 128;  // bytes
  localparam int UNCACHED_SEG = 32;   // bytes, also strict fallback granule
  localparam logic [2:0] SIZE_WIDE = 3'd4;  // 16-byte elements

  typedef enum logic [1:0] {
    MODE_CACHED   = 2'd0,
    MODE_UNCACHED = 2'd1,
    MODE_STRICT   = 2'd2
  } mode_e;

  typedef struct packed {
    logic load;  // capture a new request
    logic fire;  // current transaction handed off
  } strobe_t;
endpackage

// File: rtl/coalesce_ctrl.sv
module coalesce_ctrl
  import coalesce_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    txReady,
  input  logic    reqEmpty,
  input  logic    lastTx,
  output strobe_t strobe,
  output logic    reqReady,
  output logic    txValid,
  output logic    done
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e state;

  assign reqReady    = (state == ST_IDLE);
  assign txValid     = (state == ST_BUSY);
  assign strobe.load = reqReady && reqValid;
  assign strobe.fire = txValid && txReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (strobe.load && reqEmpty) || (strobe.fire && lastTx);
      if (strobe.load && !reqEmpty)     state <= ST_BUSY;
      else if (strobe.fire && lastTx)   state <= ST_IDLE;
    end
  end

  // R9: a pending transaction is never withdrawn
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);
  // R10: completion follows the final handshake
  p_done_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && lastTx |=> done && !txValid && reqReady);
  // R4: empty request finishes without traffic
  p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && reqEmpty |=> done && !txValid);
endmodule

// File: rtl/coalesce_datapath.sv
module coalesce_datapath
  import coalesce_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]        reqMask,
  input  logic [2:0]              reqSize,
  input  mode_e                   reqMode,
  output logic [ADDR_W-1:0]       txAddr,
  output logic [LANES-1:0]        txLanes,
  output logic                    reqEmpty,
  output logic                    lastTx
);
  localparam int LANE_W   = $clog2(LANES);
  localparam int GROUPS   = LANES / GROUP_LANES;
  localparam int GROUP_SH = $clog2(GROUP_LANES);
  localparam logic [ADDR_W-1:0] CACHED_MASK   = ~ADDR_W'(CACHED_SEG - 1);
  localparam logic [ADDR_W-1:0] UNCACHED_MASK = ~ADDR_W'(UNCACHED_SEG - 1);

  logic [ADDR_W-1:0] addrQ [LANES];
  logic [LANES-1:0]  maskQ, pendQ;
  logic [2:0]        sizeQ;
  mode_e             modeQ;

  always_ff @(posedge clk) begin
    if (strobe.load)
      for (int i = 0; i < LANES; i++) addrQ[i] <= reqAddr[i*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      pendQ <= '0;
      sizeQ <= '0;
      modeQ <= MODE_CACHED;
    end else if (strobe.load) begin
      maskQ <= reqMask;
      pendQ <= reqMask;
      sizeQ <= reqSize;
      modeQ <= reqMode;
    end else if (strobe.fire) begin
      pendQ <= pendQ & ~txLanes;
    end
  end

  // Strict-mode pattern test, one per 16-lane group
  logic [3:0]        wBits;
  logic [ADDR_W-1:0] lowMask;
  logic [GROUPS-1:0] mergeOk;
  assign wBits   = {1'b0, sizeQ} + 4'd4;
  assign lowMask = (ADDR_W'(1) << wBits) - ADDR_W'(1);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic              found;
    logic [ADDR_W-1:0] refHi;
    always_comb begin
      mergeOk[g] = 1'b1;
      found      = 1'b0;
      refHi      = '0;
      for (int k = 0; k < GROUP_LANES; k++) begin
        if (maskQ[g*GROUP_LANES + k]) begin
          if (!found) begin
            found = 1'b1;
            refHi = addrQ[g*GROUP_LANES + k] >> wBits;
          end
          if ((addrQ[g*GROUP_LANES + k] >> wBits) != refHi) mergeOk[g] = 1'b0;
          if ((addrQ[g*GROUP_LANES + k] & lowMask) != (ADDR_W'(k) << sizeQ))
            mergeOk[g] = 1'b0;
        end
      end
    end
  end

  // Leader: lowest unserved lane
  logic [LANE_W-1:0] leader;
  logic [ADDR_W-1:0] leadAddr;
  logic              leadMerge;
  always_comb begin
    leader = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pendQ[i]) leader = LANE_W'(i);
  end
  assign leadAddr = addrQ[leader];

  always_comb begin
    leadMerge = 1'b0;
    for (int g = 0; g < GROUPS; g++)
      if ((leader >> GROUP_SH) == LANE_W'(g)) leadMerge = mergeOk[g];
  end

  // Transaction selection
  logic [ADDR_W-1:0] segMask;
  always_comb begin
    segMask = (modeQ == MODE_UNCACHED) ? UNCACHED_MASK : CACHED_MASK;
    txAddr  = '0;
    txLanes = '0;
    if (modeQ != MODE_STRICT) begin
      txAddr = leadAddr & segMask;
      for (int i = 0; i < LANES; i++)
        txLanes[i] = pendQ[i] && ((addrQ[i] & segMask) == txAddr);
    end else if (!leadMerge) begin
      txAddr          = leadAddr & UNCACHED_MASK;
      txLanes[leader] = 1'b1;
    end else if (sizeQ == SIZE_WIDE) begin
      txAddr = leadAddr & CACHED_MASK;
      for (int i = 0; i < LANES; i++)
        txLanes[i] = pendQ[i] && ((LANE_W'(i) >> (GROUP_SH - 1)) == (leader >> (GROUP_SH - 1)));
    end else begin
      txAddr = leadAddr & ~lowMask;
      for (int i = 0; i < LANES; i++)
        txLanes[i] = pendQ[i] && ((LANE_W'(i) >> GROUP_SH) == (leader >> GROUP_SH));
    end
  end

  assign reqEmpty = (reqMask == '0);
  assign lastTx   = ((pendQ & ~txLanes) == '0);

  // R2: a served lane is gone after its handshake
  p_served_cleared_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> (pendQ & $past(txLanes)) == '0);
  // R2: cached segments are 128-byte aligned
  p_cached_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ != '0 && modeQ == MODE_CACHED) |-> txAddr[6:0] == '0);
  // R3: uncached segments are 32-byte aligned
  p_uncached_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ != '0 && modeQ == MODE_UNCACHED) |-> txAddr[4:0] == '0);
  // R4: only active lanes are served
  p_active_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ != '0) |-> (txLanes & ~maskQ) == '0);
  // R8: fallback transactions serve exactly one lane
  p_fallback_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ != '0 && modeQ == MODE_STRICT && !leadMerge) |-> $countones(txLanes) == 1);
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coalesce_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]        reqMask,
  input  logic [2:0]              reqSize,
  input  logic [1:0]              reqMode,
  output logic                    txValid,
  input  logic                    txReady,
  output logic [ADDR_W-1:0]       txAddr,
  output logic [LANES-1:0]        txLanes,
  output logic                    done
);
  strobe_t strobe;
  logic    reqEmpty, lastTx;

  coalesce_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .txReady(txReady),
    .reqEmpty(reqEmpty), .lastTx(lastTx), .strobe(strobe),
    .reqReady(reqReady), .txValid(txValid), .done(done)
  );

  coalesce_datapath #(.LANES(LANES), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqMask(reqMask), .reqSize(reqSize), .reqMode(mode_e'(reqMode)),
    .txAddr(txAddr), .txLanes(txLanes), .reqEmpty(reqEmpty), .lastTx(lastTx)
  );

  // R9: transaction content frozen under backpressure
  p_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> $stable(txAddr) && $stable(txLanes));
endmodule

// File: tb/test_warp_coalescer.sv
`timescale 1ns/1ps
module test_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rstN, reqValid, reqReady, txValid, txReady, done;
  logic [LANES*AW-1:0]  reqAddr;
  logic [LANES-1:0]     reqMask, txLanes;
  logic [2:0]           reqSize;
  logic [1:0]           reqMode;
  logic [AW-1:0]        txAddr;

  warp_coalescer #(.LANES(LANES), .ADDR_W(AW)) i_warp_coalescer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqMask(reqMask), .reqSize(reqSize), .reqMode(reqMode),
    .txValid(txValid), .txReady(txReady), .txAddr(txAddr), .txLanes(txLanes),
    .done(done)
  );

  int checks = 0;
  int errors = 0;

  logic [AW-1:0]    la [LANES];
  logic [LANES-1:0] lm;
  logic [2:0]       sz;
  logic [1:0]       md;
  logic [AW-1:0]    expA [64];
  logic [LANES-1:0] expL [64];
  string            expTag [64];
  int               expN;
  int               obsN;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Independent model built from the requirements
  task automatic model();
    logic [LANES-1:0] pend;
    bit               hOk [2];
    int               s;
    s = 1 << sz;
    for (int h = 0; h < 2; h++) begin
      logic [AW-1:0] base;
      bit found;
      hOk[h] = 1; found = 0; base = '0;
      for (int k = 0; k < 16; k++) begin
        if (lm[h*16+k]) begin
          if (!found) begin
            found = 1;
            base  = la[h*16+k] - AW'(k*s);
            if ((base % AW'(16*s)) != 0) hOk[h] = 0;
          end
          if (la[h*16+k] != base + AW'(k*s)) hOk[h] = 0;
        end
      end
    end
    pend = lm;
    expN = 0;
    while (pend != 0) begin
      int ld;
      logic [LANES-1:0] ln;
      logic [AW-1:0]    a;
      ld = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) ld = i;
      ln = '0;
      if (md != 2) begin
        logic [AW-1:0] seg;
        seg = (md == 1) ? 32'd32 : 32'd128;
        a = la[ld] - (la[ld] % seg);
        for (int i = 0; i < LANES; i++)
          if (pend[i] && (la[i] - (la[i] % seg)) == a) ln[i] = 1'b1;
        expTag[expN] = (md == 1) ? "R3" : "R2";
      end else if (!hOk[ld/16]) begin
        a = la[ld] - (la[ld] % 32);
        ln[ld] = 1'b1;
        expTag[expN] = "R8";
      end else if (sz == 3'd4) begin
        a = la[ld] - (la[ld] % 128);
        for (int i = 0; i < LANES; i++) if (pend[i] && i/8 == ld/8) ln[i] = 1'b1;
        expTag[expN] = "R7";
      end else begin
        a = la[ld] - (la[ld] % AW'(16*s));
        for (int i = 0; i < LANES; i++) if (pend[i] && i/16 == ld/16) ln[i] = 1'b1;
        expTag[expN] = "R6";
      end
      expA[expN] = a;
      expL[expN] = ln;
      expN++;
      pend = pend & ~ln;
    end
  endtask

  // Issue the request held in la/lm/sz/md and follow it to completion
  task automatic runReq();
    logic [AW-1:0]    holdA;
    logic [LANES-1:0] holdL;
    bit               stalled;
    model();
    @(negedge clk);
    for (int i = 0; i < LANES; i++) reqAddr[i*AW +: AW] = la[i];
    reqMask = lm; reqSize = sz; reqMode = md; reqValid = 1'b1;
    chk(reqReady, "R10", "reqReady before accept", 64'(reqReady), 64'd1);
    @(negedge clk);
    reqValid = 1'b0;
    obsN = 0;
    stalled = 0;
    holdA = '0; holdL = '0;
    while (obsN < expN) begin
      bit rdy;
      chk(txValid, expTag[obsN], "txValid", 64'(txValid), 64'd1);
      chk(txAddr == expA[obsN], expTag[obsN], "txAddr", 64'(txAddr), 64'(expA[obsN]));
      chk(txLanes == expL[obsN], expTag[obsN], "txLanes", 64'(txLanes), 64'(expL[obsN]));
      chk((txLanes & ~lm) == 0, "R4", "inactive lane served", 64'(txLanes), 64'(lm));
      chk(!reqReady && !done, "R10", "reqReady/done while busy",
          64'({reqReady, done}), 64'd0);
      if (stalled)
        chk(txAddr == holdA && txLanes == holdL, "R9", "held transaction",
            64'(txAddr), 64'(holdA));
      rdy = ($urandom % 4) != 0;
      txReady = rdy;
      // R10: offer a stray request while busy; it must be ignored
      reqValid = ($urandom % 3) == 0;
      for (int i = 0; i < LANES; i++) reqAddr[i*AW +: AW] = $urandom;
      reqMask = $urandom;
      stalled = !rdy;
      holdA = txAddr; holdL = txLanes;
      @(negedge clk);
      if (rdy) obsN++;
    end
    reqValid = 1'b0;
    txReady  = 1'b0;
    chk(done, "R10", "done after last handshake", 64'(done), 64'd1);
    chk(!txValid, "R10", "txValid after last handshake", 64'(txValid), 64'd0);
    @(negedge clk);
    chk(!done, "R10", "done is a single pulse", 64'(done), 64'd0);
    chk(obsN == expN, "R2", "transaction count", 64'(obsN), 64'(expN));
  endtask

  task automatic seqFill(input logic [AW-1:0] base, input int stride);
    for (int i = 0; i < LANES; i++) la[i] = base + AW'(i * stride);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; txReady = 1'b0;
    reqAddr = '0; reqMask = '0; reqSize = '0; reqMode = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!txValid && !done && reqReady, "R1", "reset state",
        64'({txValid, done, reqReady}), 64'b001);

    // R2: contiguous 4-byte words, cached -> one 128B block per 32 lanes
    lm = '1; sz = 3'd2; md = 2'd0; seqFill(32'h0000_1000, 4);
    runReq();
    chk(obsN == 1, "R2", "contiguous cached count", 64'(obsN), 64'd1);

    // R3: same pattern uncached -> four 32B segments
    md = 2'd1; runReq();
    chk(obsN == 4, "R3", "contiguous uncached count", 64'(obsN), 64'd4);

    // R5: broadcast address, both relaxed modes
    for (int i = 0; i < LANES; i++) la[i] = 32'h0000_2344;
    md = 2'd0; runReq();
    chk(obsN == 1, "R5", "broadcast cached count", 64'(obsN), 64'd1);
    md = 2'd1; runReq();
    chk(obsN == 1, "R5", "broadcast uncached count", 64'(obsN), 64'd1);

    // R4: empty mask
    lm = '0; md = 2'd0;
    @(negedge clk);
    reqMask = '0; reqMode = 2'd0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(done && !txValid && reqReady, "R4", "empty mask completes",
        64'({done, txValid, reqReady}), 64'b101);
    @(negedge clk);
    chk(!done && !txValid, "R4", "empty mask no traffic", 64'({done, txValid}), 64'd0);

    // R6: strict sequential 4-byte with holes -> 2 transactions
    lm = 32'hF7FF_FFFE; sz = 3'd2; md = 2'd2; seqFill(32'h0000_4000, 4);
    runReq();
    chk(obsN == 2, "R6", "strict sequential count", 64'(obsN), 64'd2);

    // R7: strict 16-byte elements -> 4 transactions
    sz = 3'd4; lm = '1; seqFill(32'h0000_8000, 16);
    runReq();
    chk(obsN == 4, "R7", "strict wide count", 64'(obsN), 64'd4);

    // R8: strict with lanes 3/4 swapped in the lower half -> 16 + 1
    sz = 3'd2; lm = '1; seqFill(32'h0000_4000, 4);
    la[3] = 32'h0000_4010; la[4] = 32'h0000_400C;
    runReq();
    chk(obsN == 17, "R8", "strict fallback count", 64'(obsN), 64'd17);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int kind;
      logic [AW-1:0] base;
      md   = 2'($urandom % 3);
      sz   = 3'($urandom % 5);
      kind = $urandom % 4;
      base = $urandom & 32'h00FF_F000;
      case ($urandom % 3)
        0: lm = '1;
        1: lm = $urandom;
        default: lm = $urandom & $urandom & $urandom;
      endcase
      case (kind)
        0: begin
          seqFill(base, 1 << sz);
          if (($urandom % 3) == 0) begin
            int j;
            j = $urandom % LANES;
            la[j] = la[j] + 32'd1;
          end
        end
        1: begin
          int strides [6] = '{0, 4, 8, 32, 64, 128};
          seqFill(base + ($urandom % 64), strides[$urandom % 6]);
        end
        2: for (int i = 0; i < LANES; i++) la[i] = base + ($urandom % 512);
        default: for (int i = 0; i < LANES; i++) la[i] = $urandom;
      endcase
      runReq();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule